// File: doc/BRIEF.md
# Parallel ATA strobe timing generator

This block paces the read and write strobes of one parallel ATA channel that carries two drives. It runs on the 33 MHz channel clock and keeps two configuration words: a 16-bit primary timing word, and a slave word that can give drive 1 its own settings. A simple register port writes either word, and the word picked by the address is always visible on a read-back bus.

Each cycle request carries the target drive, whether it goes to the data port, whether it is a DMA or a PIO transfer, and its direction. When the request is accepted, the block resolves the timing for that access. Fast timing comes from either the primary or the slave fields. Compatible timing uses the slowest settings. The block then drives the active-low read or write strobe and, if enabled, waits on the drive's ready line. After that it holds a recovery gap and raises a one-clock done pulse. A new request is taken only once the block is idle again. A decode-enable bit gates the whole channel.

Top module: `pata_strobe_timer`

## Requirements
- R1: After synchronous reset both timing words read 0000h, both strobes are high (inactive) and done is low.
- R2: Address 0 selects the primary word and address 1 selects the slave word, for writes and for `rd_data`. Only slave bits [3:2] (sample code) and [1:0] (recovery code) are kept. Its other bits read as zero.
- R3: Primary bits 11:10 always read as zero, whatever was written to them.
- R4: Under fast timing the sample code gives the strobe width in clocks, counted from strobe assertion to the first ready sample: 00 gives 5, 01 gives 4, 10 gives 3, and 11 is treated as 5. Primary sample code is bits [13:12].
- R5: Under fast timing the recovery code gives the clocks from the strobe's release to the done pulse: 00 gives 4, 01 gives 3, 10 gives 2, 11 gives 1. Primary recovery code is bits [9:8].
- R6: With primary bit 14 clear, both drives use the primary codes. With it set, drive 1 uses the slave codes and drive 0 keeps the primary codes.
- R7: Fast timing is used only for data-port accesses to a drive whose fast-bank bit is set: bit 0 for drive 0, bit 4 for drive 1. All other accesses use compatible timing: a 5-clock strobe, a 4-clock recovery, and no ready sampling.
- R8: When a drive's DMA-only bit is set (bit 3 for drive 0, bit 7 for drive 1), fast timing applies only to its DMA transfers. Its PIO data-port transfers use compatible timing.
- R9: When a drive's ready-enable bit is set (bit 1 for drive 0, bit 5 for drive 1) under fast timing, a low ready line at the sample point holds the strobe asserted. The strobe is released at the first clock edge that samples ready high. When the bit is clear, the ready line is ignored.
- R10: While primary bit 15 (decode enable) is clear, requests are ignored: no strobe and no done.
- R11: Done is high for exactly one clock per completed cycle. Requests presented while a cycle is in progress are ignored.
- R12: A write request drives only `iow_n` low. A read request drives only `ior_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 33 MHz channel clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = primary word, 1 = slave word |
| reg_wdata | input | 16 | Register write data |
| rd_data | output | 16 | Contents of the word selected by reg_addr |
| req_valid | input | 1 | Cycle request |
| req_drive | input | 1 | Target drive (0 or 1) |
| req_data_port | input | 1 | Access is to the data port |
| req_dma | input | 1 | 1 = DMA transfer, 0 = PIO |
| req_write | input | 1 | 1 = write, 0 = read |
| iordy | input | 1 | Drive ready line |
| ior_n | output | 1 | Active-low read strobe |
| iow_n | output | 1 | Active-low write strobe |
| done | output | 1 | One-clock pulse at the end of recovery |

## Verification
A wrong timing choice shows up at the ports within one transfer. A strobe held one clock too long or too short points to a bad sample-code decode or a bad timing source. A done pulse that arrives early or late points to a bad recovery decode. A stuck cycle state shows up the same way: a strobe that never releases, a done pulse that never comes, or a second strobe during recovery. Each of these can be seen within a few clocks of the affected request. The directed scenarios measure strobe width and recovery gap, clock by clock, for every source-selection path.

// File: rtl/pata_pkg.sv
package pata_pkg;
  localparam int REG_W = 16;
  localparam int CNT_W = 3;
  localparam logic [REG_W-1:0] PRIM_KEEP  = 16'hF3FF;
  localparam logic [REG_W-1:0] SLAVE_KEEP = 16'h000F;
  localparam logic [CNT_W-1:0] COMPAT_STROBE = 3'd5;
  localparam logic [CNT_W-1:0] COMPAT_RECOV  = 3'd4;

  typedef struct packed {
    logic [CNT_W-1:0] strobe_clks;
    logic [CNT_W-1:0] recov_clks;
    logic             use_iordy;
  } timing_t;

  typedef enum logic [1:0] {ST_IDLE, ST_STROBE, ST_RECOV} phase_e;

  function automatic logic [CNT_W-1:0] sample_decode(input logic [1:0] code);
    case (code)
      2'b01:   return 3'd4;
      2'b10:   return 3'd3;
      default: return 3'd5; // 00 and the reserved 11
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] recov_decode(input logic [1:0] code);
    return 3'd4 - {1'b0, code};
  endfunction
endpackage

// File: rtl/pata_timing_regs.sv
module pata_timing_regs
  import pata_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] prim_q,
  output logic [REG_W-1:0] slave_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      prim_q  <= '0;
      slave_q <= '0;
    end else if (we) begin
      if (addr) slave_q <= wdata & SLAVE_KEEP;
      else      prim_q  <= wdata & PRIM_KEEP;
    end
  end

  // R3: reserved field stays clear after any primary write
  a_r3_reserved_clear: assert property (@(posedge clk) disable iff (rst)
    (we && !addr) |=> (prim_q[11:10] == 2'b00));
  // R2: slave timing codes land as written
  a_r2_slave_codes: assert property (@(posedge clk) disable iff (rst)
    (we && addr) |=> (slave_q[3:0] == $past(wdata[3:0])));
endmodule

// File: rtl/pata_timing_sel.sv
module pata_timing_sel
  import pata_pkg::*;
(
  input  logic [REG_W-1:0] prim_q,
  input  logic [REG_W-1:0] slave_q,
  input  logic             drive,
  input  logic             data_port,
  input  logic             dma,
  output timing_t          tm
);
  logic       fast_bank, dma_only, iordy_en, use_fast, use_slave;
  logic [1:0] samp_code, rec_code;

  always_comb begin
    fast_bank = drive ? prim_q[4] : prim_q[0];
    dma_only  = drive ? prim_q[7] : prim_q[3];
    iordy_en  = drive ? prim_q[5] : prim_q[1];
    use_slave = drive && prim_q[14];
    samp_code = use_slave ? slave_q[3:2] : prim_q[13:12];
    rec_code  = use_slave ? slave_q[1:0] : prim_q[9:8];
    use_fast  = data_port && fast_bank && (!dma_only || dma);
    if (use_fast) begin
      tm.strobe_clks = sample_decode(samp_code);
      tm.recov_clks  = recov_decode(rec_code);
      tm.use_iordy   = iordy_en;
    end else begin
      tm.strobe_clks = COMPAT_STROBE;
      tm.recov_clks  = COMPAT_RECOV;
      tm.use_iordy   = 1'b0;
    end
  end
endmodule

// File: rtl/pata_strobe_fsm.sv
module pata_strobe_fsm
  import pata_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    req_valid,
  input  logic    req_write,
  input  logic    dec_en,
  input  timing_t tm,
  input  logic    iordy,
  output logic    ior_n,
  output logic    iow_n,
  output logic    done
);
  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] rec_hold;
  logic             watch_rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= ST_IDLE;
      cnt       <= '0;
      rec_hold  <= '0;
      watch_rdy <= 1'b0;
      ior_n     <= 1'b1;
      iow_n     <= 1'b1;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        ST_IDLE: if (req_valid && dec_en) begin
          phase     <= ST_STROBE;
          cnt       <= tm.strobe_clks - 3'd1;
          rec_hold  <= tm.recov_clks;
          watch_rdy <= tm.use_iordy;
          if (req_write) iow_n <= 1'b0;
          else           ior_n <= 1'b0;
        end
        ST_STROBE: begin
          if (cnt != '0) cnt <= cnt - 3'd1;
          else if (!watch_rdy || iordy) begin
            ior_n <= 1'b1;
            iow_n <= 1'b1;
            phase <= ST_RECOV;
            cnt   <= rec_hold - 3'd1;
          end
        end
        ST_RECOV: begin
          if (cnt != '0) cnt <= cnt - 3'd1;
          else begin
            phase <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end

  // R10: a disabled channel never starts a strobe
  a_r10_gate_off: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_IDLE && !dec_en) |=> (ior_n && iow_n));
  // R12: never both strobes at once
  a_r12_single_strobe: assert property (@(posedge clk) disable iff (rst)
    (ior_n || iow_n));
  // R11: done lasts one clock
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9: a low ready line at the sample point keeps the strobe on
  a_r9_ready_stretch: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_STROBE && cnt == '0 && watch_rdy && !iordy) |=> (!ior_n || !iow_n));
  // R5: recovery is quiet on both strobes
  a_r5_recov_quiet: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_RECOV) |-> (ior_n && iow_n));
  // R4: resolved strobe width stays in the legal range
  a_r4_width_range: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_IDLE && req_valid && dec_en) |-> (tm.strobe_clks >= 3'd3 && tm.strobe_clks <= 3'd5));
endmodule

// File: rtl/pata_strobe_timer.sv
module pata_strobe_timer
  import pata_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic        reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] rd_data,
  input  logic        req_valid,
  input  logic        req_drive,
  input  logic        req_data_port,
  input  logic        req_dma,
  input  logic        req_write,
  input  logic        iordy,
  output logic        ior_n,
  output logic        iow_n,
  output logic        done
);
  logic [REG_W-1:0] prim_q, slave_q;
  timing_t          tm;

  pata_timing_regs u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .prim_q(prim_q), .slave_q(slave_q)
  );

  assign rd_data = reg_addr ? slave_q : prim_q;

  pata_timing_sel u_sel (
    .prim_q(prim_q), .slave_q(slave_q), .drive(req_drive),
    .data_port(req_data_port), .dma(req_dma), .tm(tm)
  );

  pata_strobe_fsm u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .dec_en(prim_q[15]), .tm(tm), .iordy(iordy),
    .ior_n(ior_n), .iow_n(iow_n), .done(done)
  );
endmodule

// File: tb/test_pata_strobe_timer.sv
`timescale 1ns/1ps
module test_pata_strobe_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0, reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] rd_data;
  logic        req_valid = 1'b0, req_drive = 1'b0, req_data_port = 1'b0;
  logic        req_dma = 1'b0, req_write = 1'b0, iordy = 1'b1;
  logic        ior_n, iow_n, done;
  int          checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  pata_strobe_timer i_pata_strobe_timer (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_data(rd_data), .req_valid(req_valid), .req_drive(req_drive),
    .req_data_port(req_data_port), .req_dma(req_dma), .req_write(req_write),
    .iordy(iordy), .ior_n(ior_n), .iow_n(iow_n), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic read_reg(input string req, input logic a, input logic [15:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, int'(rd_data), int'(exp));
  endtask

  // hold: 0 = ready high, -1 = ready low throughout, >0 = release on that low sample
  task automatic run_xfer(input string req, input logic drv, input logic dp, input logic dma,
                          input logic wr, input int hold, input int exp_n, input int exp_r);
    int  lowc = 0, recc = 0;
    bit  other_hit = 0;
    @(negedge clk);
    iordy = (hold == 0);
    req_drive = drv; req_data_port = dp; req_dma = dma; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while ((wr ? iow_n : ior_n) == 1'b0 && lowc < 40) begin
      lowc++;
      if ((wr ? ior_n : iow_n) == 1'b0) other_hit = 1;
      if (hold > 0 && lowc == hold) iordy = 1'b1;
      @(negedge clk);
    end
    while (!done && recc < 40) begin
      recc++;
      if (!ior_n || !iow_n) other_hit = 1;
      @(negedge clk);
    end
    iordy = 1'b1;
    check({req, " strobe width"}, lowc, exp_n);
    check({req, " recovery"}, recc, exp_r);
    check({req, " R12 other strobe idle"}, int'(other_hit), 0);
    @(negedge clk);
    check({req, " R11 done one clock"}, int'(done), 0);
  endtask

  task automatic t_reset;
    read_reg("R1 primary reset", 1'b0, 16'h0000);
    read_reg("R1 slave reset", 1'b1, 16'h0000);
    check("R1 ior_n idle", int'(ior_n), 1);
    check("R1 iow_n idle", int'(iow_n), 1);
    check("R1 done low", int'(done), 0);
  endtask

  task automatic t_regs;
    write_reg(1'b0, 16'hFFFF);
    read_reg("R3 reserved bits zero", 1'b0, 16'hF3FF);
    write_reg(1'b1, 16'hFFFF);
    read_reg("R2 slave keeps codes only", 1'b1, 16'h000F);
    write_reg(1'b1, 16'h0000);
  endtask

  task automatic t_compat;
    write_reg(1'b0, 16'h8000);
    run_xfer("R7 compat read d0", 1'b0, 1'b1, 1'b0, 1'b0, 0, 5, 4);
  endtask

  task automatic t_fast_codes;
    write_reg(1'b0, 16'hA301);
    run_xfer("R4 R5 fast 3/1 read", 1'b0, 1'b1, 1'b0, 1'b0, 0, 3, 1);
    run_xfer("R12 fast write", 1'b0, 1'b1, 1'b0, 1'b1, 0, 3, 1);
    run_xfer("R7 non-data port compat", 1'b0, 1'b0, 1'b0, 1'b0, 0, 5, 4);
    write_reg(1'b0, 16'h9101);
    run_xfer("R4 R5 fast 4/3", 1'b0, 1'b1, 1'b0, 1'b0, 0, 4, 3);
    write_reg(1'b0, 16'hB201);
    run_xfer("R4 R5 reserved code 5/2", 1'b0, 1'b1, 1'b0, 1'b0, 0, 5, 2);
  endtask

  task automatic t_separate;
    write_reg(1'b0, 16'hA311);
    write_reg(1'b1, 16'h0006);
    run_xfer("R6 shared drive1", 1'b1, 1'b1, 1'b0, 1'b0, 0, 3, 1);
    write_reg(1'b0, 16'hE311);
    run_xfer("R6 separate drive1", 1'b1, 1'b1, 1'b0, 1'b0, 0, 4, 2);
    run_xfer("R6 separate drive0", 1'b0, 1'b1, 1'b0, 1'b0, 0, 3, 1);
  endtask

  task automatic t_dma_only;
    write_reg(1'b0, 16'hA309);
    run_xfer("R8 dma-only pio compat", 1'b0, 1'b1, 1'b0, 1'b0, 0, 5, 4);
    run_xfer("R8 dma-only dma fast", 1'b0, 1'b1, 1'b1, 1'b0, 0, 3, 1);
  endtask

  task automatic t_ready;
    write_reg(1'b0, 16'hA303);
    run_xfer("R9 ready stretch", 1'b0, 1'b1, 1'b0, 1'b0, 6, 6, 1);
    write_reg(1'b0, 16'hA301);
    run_xfer("R9 ready ignored", 1'b0, 1'b1, 1'b0, 1'b0, -1, 3, 1);
  endtask

  task automatic t_gate;
    int strobed = 0, doned = 0;
    write_reg(1'b0, 16'h2301);
    @(negedge clk);
    req_data_port = 1'b1; req_drive = 1'b0; req_write = 1'b0; req_valid = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!ior_n || !iow_n) strobed++;
      if (done) doned++;
    end
    req_valid = 1'b0;
    check("R10 no strobe when disabled", strobed, 0);
    check("R10 no done when disabled", doned, 0);
  endtask

  task automatic t_busy;
    int wr_hits = 0, n = 0;
    write_reg(1'b0, 16'hA301);
    @(negedge clk);
    req_drive = 1'b0; req_data_port = 1'b1; req_dma = 1'b0; req_write = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_write = 1'b1;
    while (!done && n < 40) begin
      n++;
      if (!iow_n) wr_hits++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    check("R11 busy request ignored", wr_hits, 0);
    @(negedge clk);
    check("R11 no restart iow_n", int'(iow_n), 1);
    check("R11 done dropped", int'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_compat();
    t_fast_codes();
    t_separate();
    t_dma_only();
    t_ready();
    t_gate();
    t_busy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule